// File: doc/BRIEF.md
# Rate-Selectable Input FIFO

This block carries input samples from the converter clock domain into the processing clock domain. Samples come in with a valid strobe on the write clock and are stored in a small dual-clock buffer. A paced strobe reads them out on the read clock. The pacing divisor is chosen by a two-bit rate code: every read clock, every second, every fourth or every eighth. At the full rate an external enable can also gate the strobe, so that an irregular cadence such as a 1.5x decimation can draw samples only on the cycles it needs.

A one-cycle sync pulse on the read side sets how far apart the two pointers are. It puts the read pointer half the buffer depth behind the write pointer, as last seen through the synchronizer, and restarts the rate divider. This fixes the latency through the buffer no matter what the buffer held before. A bypass setting skips the buffer and hands the write-side sample and valid to the read-side outputs through one register. Writes into the buffer that find it full are dropped, and reads attempted while it is empty return no data. Each case sets its own sticky flag, and neither changes the stored contents.

Top module: `pace_fifo`

## Requirements
- R1: While reset is held, rd_valid, ovf_flag and udf_flag are all 0.
- R2: With bypass low, rate_sel values 0, 1, 2 and 3 let at most one read through every 1, 2, 4 and 8 read clocks. At rate codes 1 to 3, two reads never land on back-to-back cycles. When the write clock matches the selected rate, a 256-cycle window holds 256 >> rate_sel reads, give or take one.
- R3: With rate_sel = 0 and gate_en = 0, no read takes place: rd_valid stays low and the stored entries are kept. At rate codes 1 to 3, gate_en has no effect.
- R4: Samples leave in the order they were written. Each pointer crosses into the other domain as a Gray-coded value and changes by at most one bit per clock, except for the read pointer on a sync cycle.
- R5: A sync pulse moves the read pointer to the synchronized write pointer minus DEPTH/2, clears udf_flag, and restarts the rate divider. With the writer idle, exactly DEPTH/2 samples (8 by default) are then read, the most recent ones written, in order. With a matched, steady writer, neither flag is set after the sync.
- R6: A write attempted while the buffer holds DEPTH entries is dropped and sets ovf_flag. ovf_flag stays at 1 until wr_rst. The first DEPTH samples written are still read back intact.
- R7: A paced read attempted while the buffer is empty sets udf_flag. udf_flag stays at 1 until rd_rst or sync.
- R8: While bypass is 1 (a static setting), rd_valid and rd_data follow wr_valid and wr_data through one read-clock register, and nothing is written into the buffer, so ovf_flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Converter-side write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Sample on wr_data is to be stored |
| wr_data | input | DW (16) | Input sample |
| ovf_flag | output | 1 | Sticky overflow flag, write domain |
| rd_clk | input | 1 | Processing-side read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rate_sel | input | 2 | Read pacing: 0 full, 1 half, 2 quarter, 3 eighth |
| gate_en | input | 1 | Read gate, used only when rate_sel is 0 |
| bypass | input | 1 | Static setting: route samples around the buffer |
| sync | input | 1 | One-cycle pulse: reposition read pointer, restart divider |
| rd_valid | output | 1 | rd_data holds a sample this cycle |
| rd_data | output | DW (16) | Output sample |
| udf_flag | output | 1 | Sticky underflow flag, read domain |

## Verification
The assertions check the following on every clock: each Gray-coded pointer changes by at most one bit, both flags stay set once set, a full buffer holds the write pointer, bypass holds it too, a gated full-rate read produces nothing, reads at rate codes 1 to 3 are never back to back, and sync clears the underflow flag. Only the bench scenarios can show that sample values come out in order at each rate, that a window holds the right number of reads, and that a sync with an idle writer replays exactly the last eight samples. They are also needed to show that an overflowed buffer still returns its first sixteen samples unchanged and that bypass carries the actual data values.

// File: rtl/pace_fifo_pkg.sv
`timescale 1ns/1ps
package pace_fifo_pkg;
  localparam int unsigned RATE_W = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_DIV1 = 2'd0,
    RATE_DIV2 = 2'd1,
    RATE_DIV4 = 2'd2,
    RATE_DIV8 = 2'd3
  } rate_e;
endpackage

// File: rtl/pace_sync2.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a Gray-coded bus.
module pace_sync2 #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pace_gray2bin.sv
`timescale 1ns/1ps
module pace_gray2bin #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// File: rtl/pace_pacer.sv
`timescale 1ns/1ps
// Read-strobe generator: divide by 1/2/4/8, gate input at full rate.
module pace_pacer
  import pace_fifo_pkg::*;
#(
  parameter int unsigned CW = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  rate_e rate,
  input  logic  gate_en,
  output logic  strobe
);
  logic [CW-1:0] phase;
  logic [CW-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || restart) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  assign mask   = CW'((32'd1 << rate) - 32'd1);
  assign strobe = (rate == RATE_DIV1) ? gate_en : ((phase & mask) == '0);
endmodule

// File: rtl/pace_ram.sv
`timescale 1ns/1ps
// Simple dual-port, dual-clock storage with registered read.
module pace_ram #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pace_fifo.sv
`timescale 1ns/1ps
module pace_fifo
  import pace_fifo_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned AW          = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          ovf_flag,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic [1:0]    rate_sel,
  input  logic          gate_en,
  input  logic          bypass,
  input  logic          sync,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          udf_flag
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned GAP   = DEPTH / 2;
  localparam int unsigned CW    = (1 << RATE_W) - 1;

  // ---------------- write domain ----------------
  logic [PW-1:0] wr_bin, wr_bin_nxt, wr_gray;
  logic [PW-1:0] rd_gray_w, rd_bin_w;
  logic          full, wr_take;

  pace_sync2 #(.W(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
    .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_w)
  );
  pace_gray2bin #(.W(PW)) u_rdbin (.gray(rd_gray_w), .bin(rd_bin_w));

  assign full       = (wr_bin - rd_bin_w) == PW'(DEPTH);
  assign wr_take    = wr_valid && !bypass && !full;
  assign wr_bin_nxt = wr_take ? wr_bin + 1'b1 : wr_bin;

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wr_bin   <= '0;
      wr_gray  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      wr_bin  <= wr_bin_nxt;
      wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      if (wr_valid && !bypass && full) ovf_flag <= 1'b1;
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rd_bin, rd_bin_nxt, rd_gray;
  logic [PW-1:0] wr_gray_r, wr_bin_r;
  logic          empty, strobe, rd_try, rd_take;
  logic          fifo_vld, mode_byp, byp_vld;
  logic [DW-1:0] ram_q, byp_data;

  pace_sync2 #(.W(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
    .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_r)
  );
  pace_gray2bin #(.W(PW)) u_wrbin (.gray(wr_gray_r), .bin(wr_bin_r));

  pace_pacer #(.CW(CW)) u_pacer (
    .clk(rd_clk), .rst(rd_rst), .restart(sync),
    .rate(rate_e'(rate_sel)), .gate_en(gate_en), .strobe(strobe)
  );

  assign empty   = (rd_bin == wr_bin_r);
  assign rd_try  = strobe && !bypass && !sync;
  assign rd_take = rd_try && !empty;

  always_comb begin
    rd_bin_nxt = rd_bin;
    if (sync)         rd_bin_nxt = wr_bin_r - PW'(GAP);
    else if (rd_take) rd_bin_nxt = rd_bin + 1'b1;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_bin   <= '0;
      rd_gray  <= '0;
      udf_flag <= 1'b0;
      fifo_vld <= 1'b0;
      mode_byp <= 1'b0;
      byp_vld  <= 1'b0;
      byp_data <= '0;
    end else begin
      rd_bin   <= rd_bin_nxt;
      rd_gray  <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
      fifo_vld <= rd_take;
      mode_byp <= bypass;
      byp_vld  <= wr_valid && bypass;
      byp_data <= wr_data;
      if (sync)                  udf_flag <= 1'b0;
      else if (rd_try && empty)  udf_flag <= 1'b1;
    end
  end

  pace_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(wr_take), .waddr(wr_bin[AW-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_take), .raddr(rd_bin[AW-1:0]), .rdata(ram_q)
  );

  assign rd_data  = mode_byp ? byp_data : ram_q;
  assign rd_valid = mode_byp ? byp_vld  : fifo_vld;

  // ---------------- assertions ----------------
  p_wr_gray_step_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  p_rd_gray_step_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !sync |=> $countones(rd_gray ^ $past(rd_gray)) <= 1);

  p_full_hold_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
    full |=> $stable(wr_bin));

  p_ovf_sticky_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
    ovf_flag |=> ovf_flag);

  p_byp_nowrite_r8: assert property (@(posedge wr_clk) disable iff (wr_rst)
    bypass |=> $stable(wr_bin));

  p_udf_sticky_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (udf_flag && !sync) |=> udf_flag);

  p_sync_clear_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    sync |=> !udf_flag);

  p_gate_hold_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rate_sel == 2'd0 && !gate_en && !bypass) |=> !fifo_vld);

  p_rate_space_r2: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rate_sel != 2'd0 && $stable(rate_sel) && fifo_vld) |=> !fifo_vld);
endmodule

// File: tb/pace_fifo_test.sv
`timescale 1ns/1ps
module pace_fifo_test;
  logic        wr_clk, rd_clk;
  logic        wr_rst, rd_rst;
  logic        wr_valid;
  logic [15:0] wr_data;
  logic        ovf_flag;
  logic [1:0]  rate_sel;
  logic        gate_en, bypass, sync;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        udf_flag;

  pace_fifo uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .ovf_flag(ovf_flag), .rd_clk(rd_clk), .rd_rst(rd_rst), .rate_sel(rate_sel),
    .gate_en(gate_en), .bypass(bypass), .sync(sync), .rd_valid(rd_valid),
    .rd_data(rd_data), .udf_flag(udf_flag)
  );

  int checks = 0;
  int errors = 0;
  int wr_half = 2;
  bit wr_run = 0;
  int next_val = 1;
  int wr_count = 0;
  bit mon_on = 0;
  bit have_ref = 0;
  int ref_val = 0;
  int first_val = 0;
  int vcount = 0;

  // 250 MHz read clock; write clock offset by 1 ns so edges never meet
  initial begin rd_clk = 0; forever #2 rd_clk = ~rd_clk; end
  initial begin wr_clk = 0; #1; forever #(wr_half) wr_clk = ~wr_clk; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write driver
  initial begin
    wr_valid = 0; wr_data = '0;
    forever begin
      @(negedge wr_clk);
      if (wr_run) begin
        wr_valid = 1'b1;
        wr_data  = 16'(next_val);
        next_val++;
        wr_count++;
      end
    end
  end

  // read monitor: order check (R4)
  initial begin
    forever begin
      @(negedge rd_clk);
      if (mon_on && rd_valid) begin
        if (have_ref)
          check(int'(rd_data) == ((ref_val + 1) & 16'hFFFF), "R4 order",
                int'(rd_data), (ref_val + 1) & 16'hFFFF);
        else
          first_val = int'(rd_data);
        ref_val  = int'(rd_data);
        have_ref = 1;
        vcount++;
      end
    end
  end

  task automatic wr_stop();
    wr_run = 0;
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge rd_clk);
    wr_rst = 1; rd_rst = 1; sync = 0;
    repeat (40) @(negedge rd_clk);
    check(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    check(ovf_flag == 1'b0, "R1 ovf_flag", int'(ovf_flag), 0);
    check(udf_flag == 1'b0, "R1 udf_flag", int'(udf_flag), 0);
    wr_rst = 0; rd_rst = 0;
    @(negedge rd_clk);
  endtask

  task automatic pulse_sync();
    @(negedge rd_clk);
    sync = 1;
    @(negedge rd_clk);
    sync = 0;
    have_ref = 0;
    vcount = 0;
  endtask

  task automatic start_stream(input logic [1:0] r, input logic g);
    mon_on = 0;
    bypass = 0; rate_sel = r; gate_en = g;
    wr_half = 2 << r;
    do_reset();
    wr_count = 0;
    wr_run = 1;
    while (wr_count < 24) @(negedge rd_clk);
    pulse_sync();
    mon_on = 1;
  endtask

  // stimulus table: {rate_sel, gate_en}
  localparam logic [2:0] VEC [4] = '{3'b00_1, 3'b01_0, 3'b10_1, 3'b11_0};

  initial begin
    wr_rst = 1; rd_rst = 1; sync = 0; bypass = 0; rate_sel = 0; gate_en = 1;

    // matched-rate streams, one per rate code (R2, R3, R4, R5)
    for (int i = 0; i < 4; i++) begin
      automatic logic [1:0] r = VEC[i][2:1];
      automatic logic       g = VEC[i][0];
      automatic int n;
      automatic int exp_n = 256 >> r;
      start_stream(r, g);
      repeat (20) @(negedge rd_clk);
      vcount = 0;
      repeat (256) @(negedge rd_clk);
      n = vcount;
      check(n >= exp_n - 1 && n <= exp_n + 1, "R2 read count", n, exp_n);
      if (r != 2'd0 && !g) check(n > 0, "R3 gate ignored off full rate", n, exp_n);
      check(ovf_flag == 1'b0, "R5 no overflow after sync", int'(ovf_flag), 0);
      check(udf_flag == 1'b0, "R5 no underflow after sync", int'(udf_flag), 0);
      wr_stop();
      mon_on = 0;
    end

    // gating at full rate, drain, underflow, resync with idle writer
    start_stream(2'd0, 1'b1);
    repeat (50) @(negedge rd_clk);
    wr_stop();
    gate_en = 0;
    repeat (6) @(negedge rd_clk);
    vcount = 0;
    repeat (20) @(negedge rd_clk);
    check(vcount == 0, "R3 gated reads", vcount, 0);
    check(udf_flag == 1'b0, "R3 gated no underflow", int'(udf_flag), 0);
    gate_en = 1;
    repeat (30) @(negedge rd_clk);
    check(vcount > 0, "R3 reads resume", vcount, 1);
    check(udf_flag == 1'b1, "R7 underflow set", int'(udf_flag), 1);
    repeat (10) @(negedge rd_clk);
    check(udf_flag == 1'b1, "R7 underflow sticky", int'(udf_flag), 1);
    begin
      automatic int last_w = next_val - 1;
      pulse_sync();
      check(udf_flag == 1'b0, "R7 cleared by sync", int'(udf_flag), 0);
      repeat (30) @(negedge rd_clk);
      check(vcount == 8, "R5 replay count", vcount, 8);
      check(ref_val == last_w, "R5 replay ends at last write", ref_val, last_w);
      check(udf_flag == 1'b1, "R5 empty again", int'(udf_flag), 1);
    end
    mon_on = 0;

    // overflow with reads gated off
    begin
      automatic int v0;
      bypass = 0; rate_sel = 0; gate_en = 0; wr_half = 2;
      do_reset();
      v0 = next_val;
      wr_count = 0;
      wr_run = 1;
      while (wr_count < 40) @(negedge rd_clk);
      wr_stop();
      repeat (10) @(negedge rd_clk);
      check(ovf_flag == 1'b1, "R6 overflow set", int'(ovf_flag), 1);
      have_ref = 0; vcount = 0; mon_on = 1;
      gate_en = 1;
      repeat (40) @(negedge rd_clk);
      check(vcount == 16, "R6 stored count", vcount, 16);
      check(first_val == v0, "R6 first stored", first_val, v0);
      check(ref_val == v0 + 15, "R6 last stored", ref_val, v0 + 15);
      check(ovf_flag == 1'b1, "R6 overflow sticky", int'(ovf_flag), 1);
      check(udf_flag == 1'b1, "R7 underflow after drain", int'(udf_flag), 1);
      mon_on = 0;
    end

    // bypass
    bypass = 1; rate_sel = 0; gate_en = 1; wr_half = 2;
    do_reset();
    @(negedge wr_clk);
    wr_data = 16'hA5C3; wr_valid = 1;
    repeat (3) @(negedge rd_clk);
    check(rd_valid == 1'b1, "R8 bypass valid", int'(rd_valid), 1);
    check(rd_data == 16'hA5C3, "R8 bypass data", int'(rd_data), 'hA5C3);
    @(negedge wr_clk);
    wr_data = 16'h3C5A;
    repeat (3) @(negedge rd_clk);
    check(rd_data == 16'h3C5A, "R8 bypass data", int'(rd_data), 'h3C5A);
    have_ref = 0; vcount = 0; mon_on = 1;
    wr_count = 0;
    wr_run = 1;
    while (wr_count < 40) @(negedge rd_clk);
    wr_stop();
    repeat (3) @(negedge rd_clk);
    mon_on = 0;
    check(vcount >= 38, "R8 bypass stream", vcount, 40);
    check(rd_valid == 1'b0, "R8 bypass valid drop", int'(rd_valid), 0);
    check(ovf_flag == 1'b0, "R8 buffer untouched", int'(ovf_flag), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge rd_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule